// File: doc/BRIEF.md
# Programmable-Length Serial Output Bank

This block gives a small host controller a bank of autonomous serial transmitters. Each channel takes a 16-bit word that the host writes as two bytes over an 8-bit bus, a bit count from 8 to 16, a shift-rate choice and a line-coding mode. Once started, the channel shifts the word out by itself, most significant bit first. The host does not have to pace any bit.

Every channel drives one clock line and one data line. In plain mode the pair acts like an SPI transmit port. In Manchester mode the clock line stays low and the data line carries self-clocked bits. The eight shift rates are clock-enable strobes from a shared divider bank. All logic runs on one system clock. An address decoder in front of the channels steers each host write to one channel register. The bank is meant to be widened by raising the channel-count parameter.

Top module: `serout_bank`

## Requirements
- R1: After reset, every channel's serial clock, serial data and busy outputs are low.
- R2: Address bits [1:0] pick a channel register: 0 is the low staging byte and 1 is the high staging byte. A write to register 2 with bit 7 set starts a transfer of the staged word, sent bit 15 first.
- R3: In the start write, bits [3:0] hold the length minus one. A transfer sends exactly that many plus one bits, from 8 to 16.
- R4: A length field below 7 is treated as 7, so the transfer sends 8 bits.
- R5: In plain mode (start bit 4 = 0) each bit takes two half-periods: clock low, then clock high. Data changes only at the start of the low half and is stable while the clock is high.
- R6: Each write to register 3 shifts data bit 0 into a 4-bit select register. The three most recent bits (newest in the least significant position) pick rate source k. Every half-period after the first then lasts RATE_BASE*(k+1) system clocks, and the first lasts between 1 and that many.
- R7: In Manchester mode (start bit 4 = 1) the clock line stays low. A 0 is sent as high then low, and a 1 as low then high, each half lasting one half-period.
- R8: Busy rises on the clock edge that accepts a start and falls on the edge that ends the last half-period. While busy is low, clock and data are low.
- R9: A start or staging write to a busy channel does not alter the transfer in progress.
- R10: Address bits above bit 1 select the channel. A write affects only that channel, and at most one channel starts per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_addr | input | CHW+2 | Channel index in upper bits, register index in [1:0] |
| host_wdata | input | 8 | Host write byte |
| sclk | output | NCH | Serial clock line per channel |
| sdata | output | NCH | Serial data line per channel |
| busy | output | NCH | Transfer in progress per channel |

## Verification
On every cycle, the checker confirms that idle channels keep both lines low. It confirms that plain-mode data never moves while the clock is high or as the clock rises. It also confirms that busy rises only after a matching start write to that channel, and on no more than one channel at a time. Bit order, the exact number of bits, the clamping of short lengths, the half-period length for each rate source, the Manchester symbol polarity and the immunity of a running transfer to new writes can be shown only by the bench. The bench rebuilds each transfer from its recorded waveform and compares it with the arithmetic expectation, while sweeping every rate source and length in both modes.

// File: rtl/serout_pkg.sv
package serout_pkg;

    localparam int WORD_W    = 16;
    localparam int CNT_W     = 4;
    localparam int SRC_W     = 3;
    localparam int NSRC      = 1 << SRC_W;
    localparam int SEL_W     = 4;
    localparam int MIN_FIELD = 7;

    typedef enum logic [1:0] {
        REG_LO  = 2'd0,
        REG_HI  = 2'd1,
        REG_CTL = 2'd2,
        REG_SEL = 2'd3
    } reg_e;

    typedef struct packed {
        logic             go;
        logic [1:0]       spare;
        logic             man;
        logic [CNT_W-1:0] len_m1;
    } ctl_t;

    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
        logic              half;
        logic              man;
        logic              busy;
        logic              sclk;
        logic              sdata;
    } chan_st_t;

    function automatic logic [CNT_W-1:0] clamp_len(input logic [CNT_W-1:0] f);
        return (f < CNT_W'(MIN_FIELD)) ? CNT_W'(MIN_FIELD) : f;
    endfunction

    function automatic int src_period(input int base, input int k);
        return base * (k + 1);
    endfunction

endpackage

// File: rtl/serout_rates.sv
module serout_rates
    import serout_pkg::*;
#(
    parameter int RATE_BASE = 2
) (
    input  logic            clk,
    input  logic            rst,
    output logic [NSRC-1:0] ticks
);

    for (genvar k = 0; k < NSRC; k++) begin : g_src
        localparam int P = src_period(RATE_BASE, k);
        localparam int W = (P > 1) ? $clog2(P) : 1;
        logic [W-1:0] cnt;

        always_ff @(posedge clk) begin
            if (rst)                  cnt <= '0;
            else if (cnt == W'(P - 1)) cnt <= '0;
            else                      cnt <= cnt + 1'b1;
        end

        assign ticks[k] = (cnt == W'(P - 1));
    end

endmodule

// File: rtl/serout_decode.sv
module serout_decode
    import serout_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CHW = 2
) (
    input  logic           host_wr,
    input  logic [CHW+1:0] host_addr,
    output logic [NCH-1:0] we,
    output reg_e           rsel
);

    assign rsel = reg_e'(host_addr[1:0]);

    for (genvar i = 0; i < NCH; i++) begin : g_we
        assign we[i] = host_wr && (host_addr[CHW+1:2] == CHW'(i));
    end

endmodule

// File: rtl/serout_chan.sv
module serout_chan
    import serout_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  reg_e            rsel,
    input  logic [7:0]      wdata,
    input  logic [NSRC-1:0] ticks,
    output logic            sclk,
    output logic            sdata,
    output logic            busy
);

    logic [WORD_W-1:0] stage;
    logic [SEL_W-1:0]  sel;
    chan_st_t          st, st_n;
    ctl_t              ctl;
    logic              start, tick;

    assign ctl   = ctl_t'(wdata);
    assign start = we && (rsel == REG_CTL) && ctl.go && !st.busy;
    assign tick  = ticks[sel[SRC_W-1:0]];

    // host-visible staging and rate select
    always_ff @(posedge clk) begin
        if (rst) begin
            stage <= '0;
            sel   <= '0;
        end else if (we) begin
            case (rsel)
                REG_LO:  stage[7:0]        <= wdata;
                REG_HI:  stage[WORD_W-1:8] <= wdata;
                REG_SEL: sel               <= {sel[SEL_W-2:0], wdata[0]};
                default: ;
            endcase
        end
    end

    // shift engine: two half-periods per bit
    always_comb begin
        st_n = st;
        if (start) begin
            st_n.sh    = stage;
            st_n.cnt   = clamp_len(ctl.len_m1);
            st_n.half  = 1'b0;
            st_n.man   = ctl.man;
            st_n.busy  = 1'b1;
            st_n.sclk  = 1'b0;
            st_n.sdata = ctl.man ? ~stage[WORD_W-1] : stage[WORD_W-1];
        end else if (st.busy && tick) begin
            if (!st.half) begin
                st_n.half = 1'b1;
                if (st.man) st_n.sdata = st.sh[WORD_W-1];
                else        st_n.sclk  = 1'b1;
            end else begin
                st_n.half = 1'b0;
                st_n.sclk = 1'b0;
                if (st.cnt == '0) begin
                    st_n.busy  = 1'b0;
                    st_n.sdata = 1'b0;
                end else begin
                    st_n.cnt   = st.cnt - 1'b1;
                    st_n.sh    = st.sh << 1;
                    st_n.sdata = st.man ? ~st.sh[WORD_W-2] : st.sh[WORD_W-2];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= st_n;
    end

    assign sclk  = st.sclk;
    assign sdata = st.sdata;
    assign busy  = st.busy;

endmodule

// File: rtl/serout_bank.sv
module serout_bank
    import serout_pkg::*;
#(
    parameter int NCH       = 4,
    parameter int RATE_BASE = 2,
    parameter int CHW       = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           host_wr,
    input  logic [CHW+1:0] host_addr,
    input  logic [7:0]     host_wdata,
    output logic [NCH-1:0] sclk,
    output logic [NCH-1:0] sdata,
    output logic [NCH-1:0] busy
);

    logic [NSRC-1:0] ticks;
    logic [NCH-1:0]  we;
    reg_e            rsel;

    serout_rates #(.RATE_BASE(RATE_BASE)) u_rates (
        .clk   (clk),
        .rst   (rst),
        .ticks (ticks)
    );

    serout_decode #(.NCH(NCH), .CHW(CHW)) u_dec (
        .host_wr   (host_wr),
        .host_addr (host_addr),
        .we        (we),
        .rsel      (rsel)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        serout_chan u_ch (
            .clk   (clk),
            .rst   (rst),
            .we    (we[i]),
            .rsel  (rsel),
            .wdata (host_wdata),
            .ticks (ticks),
            .sclk  (sclk[i]),
            .sdata (sdata[i]),
            .busy  (busy[i])
        );
    end

endmodule

// File: rtl/serout_bank_chk.sv
module serout_bank_chk #(
    parameter int NCH = 4,
    parameter int CHW = 2
) (
    input logic           clk,
    input logic           rst,
    input logic           host_wr,
    input logic [CHW+1:0] host_addr,
    input logic [7:0]     host_wdata,
    input logic [NCH-1:0] sclk,
    input logic [NCH-1:0] sdata,
    input logic [NCH-1:0] busy
);

    AST_ONE_START: assert property (@(posedge clk) disable iff (rst)
        $onehot0(busy & ~$past(busy))); // R10

    for (genvar i = 0; i < NCH; i++) begin : g_a
        AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
            !busy[i] |-> (!sclk[i] && !sdata[i])); // R8

        AST_START_CAUSE: assert property (@(posedge clk) disable iff (rst)
            $rose(busy[i]) |-> $past(host_wr && host_addr[CHW+1:2] == CHW'(i)
                                     && host_addr[1:0] == 2'd2 && host_wdata[7])); // R10

        AST_HIGH_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
            (sclk[i] && $past(sclk[i])) |-> $stable(sdata[i])); // R5

        AST_RISE_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
            $rose(sclk[i]) |-> ($stable(sdata[i]) && $past(busy[i]))); // R5
    end

endmodule

bind serout_bank serout_bank_chk #(.NCH(NCH), .CHW(CHW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .sclk       (sclk),
    .sdata      (sdata),
    .busy       (busy)
);

// File: tb/tb_serout_bank.sv
`timescale 1ns/1ps
module tb_serout_bank;

    localparam int NCH       = 4;
    localparam int CHW       = 2;
    localparam int RATE_BASE = 2;
    localparam int HMAX      = 2048;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           host_wr = 1'b0;
    logic [CHW+1:0] host_addr = '0;
    logic [7:0]     host_wdata = '0;
    logic [NCH-1:0] sclk, sdata, busy;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    logic sc_h [HMAX];
    logic sd_h [HMAX];

    serout_bank #(.NCH(NCH), .RATE_BASE(RATE_BASE)) dut (
        .clk        (clk),
        .rst        (rst),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .sclk       (sclk),
        .sdata      (sdata),
        .busy       (busy)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            bad   = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=<190000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic hw(input int ch, input int r, input logic [7:0] d);
        @(negedge clk);
        host_wr    = 1'b1;
        host_addr  = {ch[CHW-1:0], r[1:0]};
        host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    // one full transfer, recorded and checked against the arithmetic model
    task automatic xfer(input int ch, input int rate, input int fld, input bit man,
                        input logic [15:0] word, input bit inject);
        int P, L, k, kf, first, idx, rises;
        bit other_bad, ok;
        logic esc, esd, b;
        P = RATE_BASE * (rate + 1);
        L = ((fld < 7) ? 7 : fld) + 1;
        hw(ch, 3, 8'h00);
        hw(ch, 3, {7'd0, rate[2]});
        hw(ch, 3, {7'd0, rate[1]});
        hw(ch, 3, {7'd0, rate[0]});
        hw(ch, 0, word[7:0]);
        hw(ch, 1, word[15:8]);
        hw(ch, 2, {1'b1, 2'b00, man, fld[3:0]});
        check(busy[ch] === 1'b1, "R8 busy after start", int'(busy[ch]), 1);
        k = 0;
        other_bad = 0;
        forever begin
            sc_h[k] = sclk[ch];
            sd_h[k] = sdata[ch];
            b = busy[ch];
            for (int j = 0; j < NCH; j++)
                if (j != ch && (busy[j] || sclk[j] || sdata[j])) other_bad = 1;
            if (!b) break;
            host_wr = 1'b0;
            if (inject) begin
                if (k == 20) begin host_wr = 1; host_addr = {ch[CHW-1:0], 2'd0}; host_wdata = ~word[7:0]; end
                if (k == 22) begin host_wr = 1; host_addr = {ch[CHW-1:0], 2'd1}; host_wdata = ~word[15:8]; end
                if (k == 24) begin host_wr = 1; host_addr = {ch[CHW-1:0], 2'd2}; host_wdata = 8'h87; end
            end
            k++;
            if (k >= HMAX - 1) break;
            @(negedge clk);
        end
        host_wr = 1'b0;
        kf = k;
        check(!b, "R8 busy clears", int'(b), 0);
        check(!other_bad, "R10 other channels idle", int'(other_bad), 0);
        first = kf - (2 * L - 1) * P;
        check(first >= 1 && first <= P, "R6 half-period length", first, P);
        if (first >= 1) begin
            for (int h = 0; h < 2 * L; h++) begin
                idx = kf - (2 * L - 1 - h) * P - 1;
                if (man) begin
                    esc = 1'b0;
                    esd = (h % 2 == 0) ? ~word[15 - h / 2] : word[15 - h / 2];
                end else begin
                    esc = (h % 2 == 1);
                    esd = word[15 - h / 2];
                end
                ok = (sc_h[idx] === esc) && (sd_h[idx] === esd);
                check(ok, man ? "R7 manchester half" : (inject ? "R9 half after rewrite" : "R2 R5 plain half"),
                      int'({sc_h[idx], sd_h[idx]}), int'({esc, esd}));
            end
        end
        rises = 0;
        for (int i = 1; i < kf; i++) if (sc_h[i] && !sc_h[i-1]) rises++;
        check(rises == (man ? 0 : L), fld < 7 ? "R4 clamped pulses" : "R3 pulse count", rises, man ? 0 : L);
        check(sclk[ch] === 1'b0 && sdata[ch] === 1'b0, "R8 idle lines", int'({sclk[ch], sdata[ch]}), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy === '0 && sclk === '0 && sdata === '0, "R1 reset state",
              int'({busy, sclk, sdata}), 0);

        // every channel through the decoder (R10)
        for (int ch = 0; ch < NCH; ch++)
            xfer(ch, 0, 15, 1'b0, 16'h1234 ^ 16'(ch * 16'h1111), 1'b0);

        // all rates x all legal lengths, plain mode (R3 R5 R6)
        for (int rate = 0; rate < 8; rate++)
            for (int fld = 7; fld < 16; fld++)
                xfer(rate % NCH, rate, fld, 1'b0, 16'hA5C3 ^ 16'(rate * 977 + fld * 131), 1'b0);

        // clamped short length fields (R4)
        for (int fld = 0; fld < 7; fld++)
            xfer(1, 1, fld, 1'b0, 16'h5A0F ^ 16'(fld * 4099), 1'b0);

        // Manchester at every rate (R7)
        for (int rate = 0; rate < 8; rate++) begin
            xfer(2, rate, 7, 1'b1, 16'hF00D ^ 16'(rate * 3331), 1'b0);
            xfer(3, rate, 15, 1'b1, 16'h6C39 ^ 16'(rate * 257), 1'b0);
        end
        xfer(0, 0, 15, 1'b1, 16'h0000, 1'b0);
        xfer(0, 0, 15, 1'b1, 16'hFFFF, 1'b0);

        // writes to a busy channel have no effect (R9)
        xfer(1, 3, 15, 1'b0, 16'hC3A5, 1'b1);
        xfer(2, 2, 12, 1'b1, 16'h9E61, 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule